// File: doc/BRIEF.md
# XOR-Encoding Switch Output Port

This block is one output port of a single-cycle wormhole mesh router. Inputs do not wait for a grant before entering the switch. Every input that wants this output presents its flit in the same cycle. The port sends the bitwise XOR of all flits it counts in that cycle. A round-robin arbiter works in parallel with the fabric and picks one winner after the fact. The winner's index travels forward as sideband, and the winner is released through a one-hot grant. The losers present the same flits again in the next cycle.

After a coded cycle, the losers form a pending set. That set shrinks by one winner per cycle until only a raw flit remains. A receiver recovers each winner's flit by XORing two successive head frames.

Wormhole switching works as follows. A head flit that is not also a tail locks the port. Its body flits then pass raw until the tail is granted. While a packet holds the lock, the pending set is frozen, and it resumes once the lock is released. Routing, links, input buffers and decoding sit outside this block.

Top module: `xop_out_port`

## Requirements
- R1: When the port is free (not locked, pending set empty) and exactly one input requests, `flit_o` equals that input's flit unmodified, `coded_o` is 0 and `valid_o` is 1.
- R2: In every cycle, `flit_o` is the XOR of the flits of all counted requesters, and 0 when none are counted. `coded_o` is 1 exactly when two or more requesters are counted.
- R3: `gnt_o` is one-hot or zero, `valid_o` equals `|gnt_o`, and `valid_o` is 1 exactly when at least one requester is counted.
- R4: The winner is the first counted requester found scanning upward (wrapping) from the round-robin pointer. `win_o` holds the winner's index (3 bits for 5 ports, 0 when idle). The pointer is 0 after reset and moves to the port after each unlocked winner.
- R5: After an unlocked grant, the counted requesters other than the winner become the pending set. While that set is non-empty and the port is unlocked, only its members are counted. As a result, the XOR of two successive head frames is the earlier winner's flit, and the last frame of a chain is raw.
- R6: A granted flit with `last_i` = 0 locks the port to its input. While the port is locked, only that input is counted, and the lock is released when that input's flit with `last_i` = 1 is granted.
- R7: While the port is locked and the owner does not request, `valid_o` is 0, `flit_o` is 0 and `gnt_o` is 0.
- R8: During and right after reset, with no requests, `valid_o`, `coded_o`, `gnt_o` and `flit_o` are all 0.
- R9: A requesting head flit is granted within 2*N_PORTS head frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PORTS | Per-input request for this output |
| last_i | input | N_PORTS | Per-input flag: the presented flit is the packet's tail |
| flit_i | input | N_PORTS*FLIT_W | Presented flits, input k at bits [k*FLIT_W +: FLIT_W] |
| valid_o | output | 1 | A flit or coded word leaves this cycle |
| coded_o | output | 1 | Output is the XOR of more than one flit |
| win_o | output | IDX_W | Index of the input the output stands for |
| gnt_o | output | N_PORTS | One-hot release to the winning input |
| flit_o | output | FLIT_W | Output data |

## Verification
The assertions assume that an input holding a head flit keeps requesting, with the same flit, until it is granted. A pending chain relies on its members staying present. Only an owner part way through a packet may drop its request, which creates a bubble. The stimulus keeps to this rule. Head requests stay asserted from the moment their packet is queued until the grant, and only body flits are stalled at random. Packets join at random times, so late arrivals meet both draining chains and held locks.

// File: rtl/xop_pkg.sv
package xop_pkg;
  typedef enum logic {HOLD_FREE = 1'b0, HOLD_BUSY = 1'b1} hold_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xop_rr_arb.sv
module xop_rr_arb #(
  parameter int unsigned N_PORTS = 5,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [N_PORTS-1:0] req_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  int unsigned         pos;
  logic [IDX_W-1:0]    cand;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    pos   = 0;
    cand  = '0;
    for (int unsigned k = 0; k < N_PORTS; k++) begin
      pos  = (int'(ptr_i) + k) % N_PORTS;
      cand = IDX_W'(pos);
      if (!any_o && req_i[cand]) begin
        any_o       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = cand;
      end
    end
  end
endmodule

// File: rtl/xop_xor_fab.sv
module xop_xor_fab #(
  parameter int unsigned N_PORTS = 5,
  parameter int unsigned FLIT_W  = 64
) (
  input  logic [N_PORTS*FLIT_W-1:0] flit_i,
  input  logic [N_PORTS-1:0]        sel_i,
  output logic [FLIT_W-1:0]         data_o
);
  logic [FLIT_W-1:0] lane [N_PORTS];

  for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
    assign lane[g] = sel_i[g] ? flit_i[g*FLIT_W +: FLIT_W] : '0;
  end

  always_comb begin
    data_o = '0;
    for (int unsigned k = 0; k < N_PORTS; k++) data_o ^= lane[k];
  end
endmodule

// File: rtl/xop_ctrl.sv
module xop_ctrl
  import xop_pkg::*;
#(
  parameter int unsigned N_PORTS = 5,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] req_i,
  input  logic [N_PORTS-1:0] last_i,
  input  logic [N_PORTS-1:0] gnt_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               any_i,
  output logic [N_PORTS-1:0] elig_o,
  output logic [IDX_W-1:0]   ptr_o
);
  hold_e              hold_q;
  logic [IDX_W-1:0]   own_q;
  logic [N_PORTS-1:0] pend_q;
  logic [IDX_W-1:0]   ptr_q;

  assign ptr_o = ptr_q;

  // locked: owner only; draining: pending members only; else everyone
  always_comb begin
    elig_o = '0;
    if (hold_q == HOLD_BUSY)  elig_o[own_q] = req_i[own_q];
    else if (|pend_q)         elig_o = req_i & pend_q;
    else                      elig_o = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= HOLD_FREE;
      own_q  <= '0;
      pend_q <= '0;
      ptr_q  <= '0;
    end else if (hold_q == HOLD_BUSY) begin
      if (gnt_i[own_q] && last_i[own_q]) hold_q <= HOLD_FREE;
    end else if (any_i) begin
      pend_q <= elig_o & ~gnt_i;
      ptr_q  <= (idx_i == IDX_W'(N_PORTS-1)) ? '0 : idx_i + 1'b1;
      if (!last_i[idx_i]) begin
        hold_q <= HOLD_BUSY;
        own_q  <= idx_i;
      end
    end
  end
endmodule

// File: rtl/xop_out_port.sv
module xop_out_port #(
  parameter int unsigned N_PORTS = 5,
  parameter int unsigned FLIT_W  = 64,
  localparam int unsigned IDX_W  = xop_pkg::idx_bits(N_PORTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS-1:0]        req_i,
  input  logic [N_PORTS-1:0]        last_i,
  input  logic [N_PORTS*FLIT_W-1:0] flit_i,
  output logic                      valid_o,
  output logic                      coded_o,
  output logic [IDX_W-1:0]          win_o,
  output logic [N_PORTS-1:0]        gnt_o,
  output logic [FLIT_W-1:0]         flit_o
);
  logic [N_PORTS-1:0] elig;
  logic [IDX_W-1:0]   ptr;
  logic               any;

  xop_ctrl #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .last_i (last_i),
    .gnt_i  (gnt_o),
    .idx_i  (win_o),
    .any_i  (any),
    .elig_o (elig),
    .ptr_o  (ptr)
  );

  xop_rr_arb #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_arb (
    .req_i (elig),
    .ptr_i (ptr),
    .gnt_o (gnt_o),
    .idx_o (win_o),
    .any_o (any)
  );

  xop_xor_fab #(.N_PORTS(N_PORTS), .FLIT_W(FLIT_W)) u_fab (
    .flit_i (flit_i),
    .sel_i  (elig),
    .data_o (flit_o)
  );

  assign valid_o = any;
  assign coded_o = |(elig & (elig - 1'b1));
endmodule

// File: rtl/xop_out_port_chk.sv
module xop_out_port_chk #(
  parameter int unsigned N_PORTS = 5,
  parameter int unsigned FLIT_W  = 64,
  localparam int unsigned IDX_W  = xop_pkg::idx_bits(N_PORTS)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_PORTS-1:0]        req_i,
  input logic [N_PORTS-1:0]        last_i,
  input logic [N_PORTS*FLIT_W-1:0] flit_i,
  input logic                      valid_o,
  input logic                      coded_o,
  input logic [IDX_W-1:0]          win_o,
  input logic [N_PORTS-1:0]        gnt_o,
  input logic [FLIT_W-1:0]         flit_o
);
  p_gnt_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (valid_o == (gnt_o != '0)));

  p_gnt_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  p_win_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> gnt_o[win_o]);

  p_coded_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coded_o |-> valid_o);

  p_raw_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !coded_o) |-> (flit_o == flit_i[win_o*FLIT_W +: FLIT_W]));

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (flit_o == '0 && !coded_o));

  p_lock_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_i[win_o]) |=> ((gnt_o & ~$past(gnt_o)) == '0));

  p_chain_shrink_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coded_o && last_i[win_o]) |=> ((gnt_o & $past(gnt_o)) == '0));

  // input rule: an ungranted request stays up
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_i & ~gnt_o & ~last_i)) |=> (($past(req_i) & ~$past(gnt_o) & ~$past(last_i) & ~req_i) == '0));
endmodule

bind xop_out_port xop_out_port_chk #(.N_PORTS(N_PORTS), .FLIT_W(FLIT_W)) u_chk (.*);

// File: tb/sim_xop_out_port.sv
module sim_xop_out_port;
  localparam int N  = 5;
  localparam int W  = 64;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  last = '0;
  logic [N*W-1:0] flit = '0;
  logic          valid_o, coded_o;
  logic [IW-1:0] win_o;
  logic [N-1:0]  gnt_o;
  logic [W-1:0]  flit_o;

  always #2 clk = ~clk;

  xop_out_port #(.N_PORTS(N), .FLIT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .last_i(last), .flit_i(flit),
    .valid_o(valid_o), .coded_o(coded_o), .win_o(win_o), .gnt_o(gnt_o), .flit_o(flit_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // per-input packet queues
  logic [W-1:0] qf [N][$];
  bit           ql [N][$];
  bit           in_pkt [N];
  int           wait_hf [N];
  int           stall_pct = 0;

  // reference state
  bit           m_held = 0;
  int           m_own = 0;
  bit [N-1:0]   m_pend = '0;
  int           m_ptr = 0;
  bit           have_prev = 0;
  logic [W-1:0] prev_word, prev_flit;

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_pkt(int p, int len);
    for (int k = 0; k < len; k++) begin
      qf[p].push_back({$urandom, $urandom});
      ql[p].push_back(k == len-1);
    end
  endtask

  task automatic step();
    bit [N-1:0]   cnt;
    logic [W-1:0] e_flit;
    int           e_win;
    bit           e_valid;
    int           n;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (qf[i].size() > 0) begin
        req[i]  = !(in_pkt[i] && (($urandom % 100) < stall_pct));
        flit[i*W +: W] = qf[i][0];
        last[i] = ql[i][0];
      end else begin
        req[i] = 1'b0; flit[i*W +: W] = '0; last[i] = 1'b0;
      end
    end
    #1;
    cnt = '0;
    if (m_held) cnt[m_own] = req[m_own];
    else if (m_pend != 0) cnt = req & m_pend;
    else cnt = req;
    e_flit = '0; n = 0; e_win = -1;
    for (int i = 0; i < N; i++) if (cnt[i]) begin e_flit ^= flit[i*W +: W]; n++; end
    for (int k = 0; k < N; k++) begin
      int j = (m_ptr + k) % N;
      if (e_win < 0 && cnt[j]) e_win = j;
    end
    e_valid = (n > 0);
    chk(valid_o == e_valid, "R3 valid", W'(valid_o), W'(e_valid));
    chk(gnt_o == (e_valid ? N'(1 << e_win) : N'(0)), "R4 grant", W'(gnt_o), e_valid ? W'(1 << e_win) : '0);
    chk(win_o == (e_valid ? IW'(e_win) : IW'(0)), "R4 win index", W'(win_o), e_valid ? W'(e_win) : '0);
    chk(flit_o == e_flit, "R2 xor data", flit_o, e_flit);
    chk(coded_o == (n > 1), "R2 coded flag", W'(coded_o), W'(n > 1));
    if (!m_held && m_pend == 0 && n == 1)
      chk(flit_o == flit[e_win*W +: W], "R1 raw pass", flit_o, flit[e_win*W +: W]);
    if (m_held && !req[m_own])
      chk(!valid_o && flit_o == '0 && gnt_o == '0, "R7 bubble", flit_o, '0);
    if (m_held && req[m_own])
      chk(gnt_o == N'(1 << m_own), "R6 lock owner", W'(gnt_o), W'(1 << m_own));
    if (e_valid && !in_pkt[e_win]) begin
      // head frame: decode chain and starvation bound
      if (have_prev)
        chk((prev_word ^ flit_o) == prev_flit, "R5 decode", prev_word ^ flit_o, prev_flit);
      else
        chk(flit_o == flit[e_win*W +: W] || n > 1, "R5 chain start", flit_o, flit[e_win*W +: W]);
      have_prev = (n > 1);
      prev_word = flit_o;
      prev_flit = flit[e_win*W +: W];
      for (int i = 0; i < N; i++) begin
        if (i == e_win) wait_hf[i] = 0;
        else if (req[i] && !in_pkt[i]) begin
          wait_hf[i]++;
          chk(wait_hf[i] <= 2*N, "R9 starvation", W'(wait_hf[i]), W'(2*N));
        end
      end
    end
    if (m_held) begin
      if (e_valid && last[m_own]) m_held = 0;
    end else if (e_valid) begin
      m_pend = cnt; m_pend[e_win] = 1'b0;
      m_ptr = (e_win + 1) % N;
      if (!last[e_win]) begin m_held = 1; m_own = e_win; end
    end
    if (e_valid) begin
      in_pkt[e_win] = !ql[e_win][0];
      void'(qf[e_win].pop_front());
      void'(ql[e_win].pop_front());
    end
  endtask

  task automatic drain(int max);
    for (int c = 0; c < max; c++) begin
      bit busy = 0;
      for (int i = 0; i < N; i++) if (qf[i].size() > 0) busy = 1;
      if (!busy) break;
      step();
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin in_pkt[i] = 0; wait_hf[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!valid_o && !coded_o && gnt_o == '0 && flit_o == '0, "R8 reset outputs", flit_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid_o && gnt_o == '0 && flit_o == '0, "R8 after reset", flit_o, '0);
    // R1: lone single-flit packet
    push_pkt(2, 1); drain(20);
    // R2, R4, R5: all five heads collide
    for (int i = 0; i < N; i++) push_pkt(i, 1);
    drain(40);
    // R6: multi-flit packet colliding with a single
    push_pkt(1, 3); push_pkt(3, 1); drain(40);
    // R7: stalled body flits
    stall_pct = 60; push_pkt(4, 4); push_pkt(0, 2); drain(80); stall_pct = 0;
    // R5: late joiner must wait out the chain
    push_pkt(0, 1); push_pkt(1, 1); step(); push_pkt(4, 1); drain(40);
    // random traffic
    stall_pct = 30;
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++)
        if (qf[i].size() == 0 && ($urandom % 100) < 25) push_pkt(i, 1 + int'($urandom % 3));
      step();
    end
    stall_pct = 0;
    drain(400);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule